// File: doc/BRIEF.md
# Endpoint Halt Status Controller

This block holds the stall state of one non-control endpoint of a USB device and the one-byte status value that the device sends back when the host asks for that endpoint's status. The control-transfer logic supplies already-decoded strobes, one per correctly received standard request. An error on the endpoint arrives as a flag. The CPU reads and writes the status byte through a plain 8-bit port. A busy flag reports that the bus side is currently moving data on the endpoint.

Hardware requests take precedence over the CPU. A halt request or an endpoint error stalls the endpoint. A clear request releases the stall and restarts the data toggle at DATA0. Each time the endpoint goes into the stalled state, the block sends a one-cycle flush to the endpoint's IN buffer and to that buffer's NAK flag. The CPU can change the halt bit only while the control endpoint is NAKing and no bus-side access to the endpoint is in progress. A status query is answered on the next cycle with the byte as it stood when the query arrived.

Top module: `ep_halt_ctrl`

## Requirements
- R1: Coming out of reset, `halt_o` is 0, `cpu_rdata_o` is 0x00, and every pulse output is 0. Bits 7 to 1 of `cpu_rdata_o` and `reply_data_o` always read 0, and bit 0 carries the halt state (1 = stalled).
- R2: On the cycle after `req_set_feature_i` or `ep_error_i` is high, `halt_o` is 1.
- R3: On the cycle after `req_clear_feature_i`, `req_set_config_i` or `req_set_intf_i` is high, `halt_o` is 0 and `toggle_rst_o` is high for that one cycle. This happens on every such request, including when the endpoint was not halted.
- R4: If a set cause and a clear cause arrive in the same cycle, the set wins. `halt_o` becomes 1 and `toggle_rst_o` stays 0.
- R5: A CPU write with `ctl_nak_i`=1 and `ep_busy_i`=0 loads `cpu_wdata_i[0]` into the halt state on the next cycle. Bits 7 to 1 of the write data are dropped.
- R6: A CPU write while `ctl_nak_i`=0 leaves the halt state unchanged.
- R7: A CPU write while `ep_busy_i`=1 leaves the halt state unchanged, even when `ctl_nak_i`=1.
- R8: A hardware set or clear in the same cycle as an accepted CPU write decides the new halt state, and the write is lost.
- R9: `buf_clr_o` and `buf_nak_clr_o` go high for exactly one cycle, in the cycle where `halt_o` changes from 0 to 1, whatever the cause. This includes a CPU write. Neither output pulses if the endpoint is already halted.
- R10: One cycle after `get_status_i`, `reply_valid_o` is high for one cycle and `reply_data_o` holds the status byte as it was in the cycle of the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_set_feature_i | input | 1 | Endpoint-halt feature set request received |
| req_clear_feature_i | input | 1 | Endpoint-halt feature clear request received |
| req_set_config_i | input | 1 | Set-configuration request received |
| req_set_intf_i | input | 1 | Set-interface request for the owning interface received |
| ep_error_i | input | 1 | Error detected on the endpoint |
| get_status_i | input | 1 | Endpoint status query received |
| cpu_wr_i | input | 1 | CPU write strobe |
| cpu_wdata_i | input | 8 | CPU write data |
| ctl_nak_i | input | 1 | Control endpoint currently NAKing |
| ep_busy_i | input | 1 | Bus-side access to the endpoint in progress |
| cpu_rdata_o | output | 8 | Status byte for CPU reads |
| halt_o | output | 1 | Endpoint stalled |
| toggle_rst_o | output | 1 | One-cycle pulse: restart the data toggle at DATA0 |
| buf_clr_o | output | 1 | One-cycle pulse: flush the endpoint IN buffer |
| buf_nak_clr_o | output | 1 | One-cycle pulse: clear the buffer NAK flag |
| reply_valid_o | output | 1 | Status reply byte valid |
| reply_data_o | output | 8 | Status reply byte |

## Verification
The assertions check these rules on every cycle: the upper bits stay zero, a set or clear cause is followed by the matching halt state, a clear produces a toggle pulse, a dropped write leaves the halt state unchanged, the flush pulses line up with a rising halt, and a reply follows each query. Some outcomes depend on how the inputs combine across many cycles. Examples are set-over-clear priority mixed with gated CPU writes, repeated halts that must not flush again, and a reply that must carry the pre-update value when a query and a state change arrive together. Only the bench scenarios show these, comparing against an independent reference model under random and directed stimulus.

// File: rtl/ep_halt_pkg.sv
package ep_halt_pkg;

  // decoded hardware causes acting on the halt state
  typedef struct packed {
    logic set;
    logic clr;
  } ep_hw_evt_t;

  // CPU write after gating
  typedef struct packed {
    logic valid;
    logic halt;
  } ep_cpu_wr_t;

endpackage

// File: rtl/ep_halt_rst_sync.sv
module ep_halt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[LAST];

endmodule

// File: rtl/ep_halt_evt.sv
module ep_halt_evt
  import ep_halt_pkg::*;
(
  input  logic       req_set_feature_i,
  input  logic       req_clear_feature_i,
  input  logic       req_set_config_i,
  input  logic       req_set_intf_i,
  input  logic       ep_error_i,
  output ep_hw_evt_t evt_o
);

  always_comb begin
    evt_o.set = req_set_feature_i | ep_error_i;
    evt_o.clr = req_clear_feature_i | req_set_config_i | req_set_intf_i;
  end

endmodule

// File: rtl/ep_halt_wgate.sv
module ep_halt_wgate
  import ep_halt_pkg::*;
#(
  parameter int unsigned STS_W    = 8,
  parameter int unsigned HALT_POS = 0
) (
  input  logic             wr_i,
  input  logic [STS_W-1:0] wdata_i,
  input  logic             ctl_nak_i,
  input  logic             ep_busy_i,
  output ep_cpu_wr_t       cpu_o
);

  // only the halt bit is storage; the other bits are dropped
  logic wdata_unused;
  assign wdata_unused = ^wdata_i;

  always_comb begin
    cpu_o.valid = wr_i & ctl_nak_i & ~ep_busy_i;
    cpu_o.halt  = wdata_i[HALT_POS];
  end

endmodule

// File: rtl/ep_halt_state.sv
module ep_halt_state
  import ep_halt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  ep_hw_evt_t evt_i,
  input  ep_cpu_wr_t cpu_i,
  output logic       halt_o,
  output logic       toggle_rst_o,
  output logic       buf_clr_o,
  output logic       buf_nak_clr_o
);

  logic halt_q, halt_d, halt_en;
  logic tog_q, tog_d;
  logic flush_q, flush_d;

  // next state: hardware set, then hardware clear, then CPU
  always_comb begin
    halt_en = 1'b0;
    halt_d  = halt_q;
    if (evt_i.set) begin
      halt_en = 1'b1;
      halt_d  = 1'b1;
    end else if (evt_i.clr) begin
      halt_en = 1'b1;
      halt_d  = 1'b0;
    end else if (cpu_i.valid) begin
      halt_en = 1'b1;
      halt_d  = cpu_i.halt;
    end
    tog_d   = evt_i.clr & ~evt_i.set;
    flush_d = halt_en & halt_d & ~halt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q  <= 1'b0;
      tog_q   <= 1'b0;
      flush_q <= 1'b0;
    end else begin
      if (halt_en) halt_q <= halt_d;
      tog_q   <= tog_d;
      flush_q <= flush_d;
    end
  end

  assign halt_o        = halt_q;
  assign toggle_rst_o  = tog_q;
  assign buf_clr_o     = flush_q;
  assign buf_nak_clr_o = flush_q;

endmodule

// File: rtl/ep_halt_reply.sv
module ep_halt_reply #(
  parameter int unsigned STS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             query_i,
  input  logic [STS_W-1:0] sts_i,
  output logic             valid_o,
  output logic [STS_W-1:0] data_o
);

  logic             valid_q, valid_d;
  logic [STS_W-1:0] data_q, data_d;

  always_comb begin
    valid_d = query_i;
    data_d  = sts_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= valid_d;
      if (query_i) data_q <= data_d;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;

endmodule

// File: rtl/ep_halt_ctrl.sv
module ep_halt_ctrl
  import ep_halt_pkg::*;
#(
  parameter int unsigned STS_W      = 8,
  parameter int unsigned HALT_POS   = 0,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_set_feature_i,
  input  logic             req_clear_feature_i,
  input  logic             req_set_config_i,
  input  logic             req_set_intf_i,
  input  logic             ep_error_i,
  input  logic             get_status_i,
  input  logic             cpu_wr_i,
  input  logic [STS_W-1:0] cpu_wdata_i,
  input  logic             ctl_nak_i,
  input  logic             ep_busy_i,
  output logic [STS_W-1:0] cpu_rdata_o,
  output logic             halt_o,
  output logic             toggle_rst_o,
  output logic             buf_clr_o,
  output logic             buf_nak_clr_o,
  output logic             reply_valid_o,
  output logic [STS_W-1:0] reply_data_o
);

  logic       srst_n;
  ep_hw_evt_t hw_evt;
  ep_cpu_wr_t cpu_wr;
  logic       halt;
  logic [STS_W-1:0] sts_byte;

  ep_halt_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n_i(rst_n), .rst_n_o(srst_n)
  );

  ep_halt_evt u_evt (
    .req_set_feature_i(req_set_feature_i),
    .req_clear_feature_i(req_clear_feature_i),
    .req_set_config_i(req_set_config_i),
    .req_set_intf_i(req_set_intf_i),
    .ep_error_i(ep_error_i),
    .evt_o(hw_evt)
  );

  ep_halt_wgate #(.STS_W(STS_W), .HALT_POS(HALT_POS)) u_wgate (
    .wr_i(cpu_wr_i), .wdata_i(cpu_wdata_i),
    .ctl_nak_i(ctl_nak_i), .ep_busy_i(ep_busy_i),
    .cpu_o(cpu_wr)
  );

  ep_halt_state u_state (
    .clk(clk), .rst_n(srst_n),
    .evt_i(hw_evt), .cpu_i(cpu_wr),
    .halt_o(halt), .toggle_rst_o(toggle_rst_o),
    .buf_clr_o(buf_clr_o), .buf_nak_clr_o(buf_nak_clr_o)
  );

  // status byte: halt bit at HALT_POS, all other bits tied low
  for (genvar i = 0; i < STS_W; i++) begin : g_sts
    if (i == HALT_POS) begin : g_halt
      assign sts_byte[i] = halt;
    end else begin : g_zero
      assign sts_byte[i] = 1'b0;
    end
  end

  ep_halt_reply #(.STS_W(STS_W)) u_reply (
    .clk(clk), .rst_n(srst_n),
    .query_i(get_status_i), .sts_i(sts_byte),
    .valid_o(reply_valid_o), .data_o(reply_data_o)
  );

  assign halt_o      = halt;
  assign cpu_rdata_o = sts_byte;

endmodule

// File: rtl/ep_halt_chk.sv
module ep_halt_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sf,
  input logic       cf,
  input logic       sc,
  input logic       si,
  input logic       err,
  input logic       gs,
  input logic       wr,
  input logic       wbit,
  input logic       nak,
  input logic       busy,
  input logic [7:0] rdata,
  input logic       halt,
  input logic       tog,
  input logic       bclr,
  input logic       bnclr,
  input logic       rvalid,
  input logic [7:0] rdat
);

  logic hs, hc, wok;
  assign hs  = sf | err;
  assign hc  = cf | sc | si;
  assign wok = wr & nak & ~busy;

  a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[7:1] == 7'd0 && rdat[7:1] == 7'd0 && rdata[0] == halt);
  a_r2_set: assert property (@(posedge clk) disable iff (!rst_n)
    hs |=> halt);
  a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (hc && !hs) |=> (!halt && tog));
  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (hc && hs) |=> (halt && !tog));
  a_r6_nak_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !nak && !hs && !hc) |=> $stable(halt));
  a_r7_busy_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && busy && !hs && !hc) |=> $stable(halt));
  a_r8_clr_beats_write: assert property (@(posedge clk) disable iff (!rst_n)
    (hc && !hs && wok && wbit) |=> !halt);
  a_r9_flush_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt) |-> (bclr && bnclr));
  a_r9_flush_only_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (bclr || bnclr) |-> (halt && !$past(halt)));
  a_r10_reply: assert property (@(posedge clk) disable iff (!rst_n)
    gs |=> (rvalid && rdat == $past(rdata)));

endmodule

bind ep_halt_ctrl ep_halt_chk u_chk (
  .clk(clk), .rst_n(srst_n),
  .sf(req_set_feature_i), .cf(req_clear_feature_i),
  .sc(req_set_config_i), .si(req_set_intf_i), .err(ep_error_i),
  .gs(get_status_i), .wr(cpu_wr_i), .wbit(cpu_wdata_i[0]),
  .nak(ctl_nak_i), .busy(ep_busy_i),
  .rdata(cpu_rdata_o), .halt(halt_o), .tog(toggle_rst_o),
  .bclr(buf_clr_o), .bnclr(buf_nak_clr_o),
  .rvalid(reply_valid_o), .rdat(reply_data_o)
);

// File: tb/ep_halt_ctrl_bench.sv
`timescale 1ns/1ps
module ep_halt_ctrl_bench;

  logic clk = 1'b0;
  logic rst_n;
  logic sf, cf, sc, si, err, gs, wr, nak, busy;
  logic [7:0] wd;
  logic [7:0] rdata, rdat;
  logic halt, tog, bclr, bnclr, rvalid;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic mh;

  always #2 clk = ~clk;

  ep_halt_ctrl u_ep_halt_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_set_feature_i(sf), .req_clear_feature_i(cf),
    .req_set_config_i(sc), .req_set_intf_i(si), .ep_error_i(err),
    .get_status_i(gs), .cpu_wr_i(wr), .cpu_wdata_i(wd),
    .ctl_nak_i(nak), .ep_busy_i(busy),
    .cpu_rdata_o(rdata), .halt_o(halt), .toggle_rst_o(tog),
    .buf_clr_o(bclr), .buf_nak_clr_o(bnclr),
    .reply_valid_o(rvalid), .reply_data_o(rdat)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic f_next(input logic h, input logic s, input logic c,
                                  input logic ok, input logic b);
    if (s) return 1'b1;
    if (c) return 1'b0;
    if (ok) return b;
    return h;
  endfunction

  function automatic string f_tag(input logic s, input logic c, input logic w,
                                  input logic ok, input logic n, input logic bz);
    if (s && c) return "R4";
    if ((s || c) && ok) return "R8";
    if (s) return "R2";
    if (c) return "R3";
    if (ok) return "R5";
    if (w && !n) return "R6";
    if (w && bz) return "R7";
    return "R1";
  endfunction

  // drive at negedge, model, check after the next rising edge
  task automatic cyc(input logic i_sf, input logic i_cf, input logic i_sc,
                     input logic i_si, input logic i_err, input logic i_gs,
                     input logic i_wr, input logic [7:0] i_wd,
                     input logic i_nak, input logic i_busy);
    logic hs, hc, ok, nh;
    string tg;
    @(negedge clk);
    sf = i_sf; cf = i_cf; sc = i_sc; si = i_si; err = i_err; gs = i_gs;
    wr = i_wr; wd = i_wd; nak = i_nak; busy = i_busy;
    hs = i_sf | i_err;
    hc = i_cf | i_sc | i_si;
    ok = i_wr & i_nak & ~i_busy;
    nh = f_next(mh, hs, hc, ok, i_wd[0]);
    tg = f_tag(hs, hc, i_wr, ok, i_nak, i_busy);
    @(posedge clk);
    #1;
    chk(tg, "halt_o", halt, nh);
    chk("R1", "cpu_rdata_o", rdata, {7'd0, nh});
    chk(hs && hc ? "R4" : "R3", "toggle_rst_o", tog, hc & ~hs);
    chk("R9", "buf_clr_o", bclr, nh & ~mh);
    chk("R9", "buf_nak_clr_o", bnclr, nh & ~mh);
    chk("R10", "reply_valid_o", rvalid, i_gs);
    if (i_gs) chk("R10", "reply_data_o", rdat, {7'd0, mh});
    mh = nh;
  endtask

  task automatic idle();
    cyc(0,0,0,0,0,0,0,8'h00,0,0);
  endtask

  initial begin
    sf = 0; cf = 0; sc = 0; si = 0; err = 0; gs = 0; wr = 0; wd = 0;
    nak = 0; busy = 0; mh = 1'b0;
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1", "reset halt_o", halt, 0);
    chk("R1", "reset cpu_rdata_o", rdata, 8'h00);
    chk("R1", "reset pulses", {tog, bclr, bnclr, rvalid}, 0);

    // R10 query while idle
    cyc(0,0,0,0,0,1,0,8'h00,0,0);
    // R2 set feature, then again while halted (R9: no second flush)
    cyc(1,0,0,0,0,0,0,8'h00,0,0);
    cyc(1,0,0,0,0,1,0,8'h00,0,0);
    // R3 each clear cause, including while not halted
    cyc(0,1,0,0,0,0,0,8'h00,0,0);
    cyc(0,0,1,0,0,0,0,8'h00,0,0);
    cyc(0,0,0,0,1,0,0,8'h00,0,0);   // R2 error
    cyc(0,0,0,1,0,0,0,8'h00,0,0);
    // R4 set and clear together
    cyc(0,0,1,0,1,0,0,8'h00,0,0);
    cyc(0,1,0,0,0,0,0,8'h00,0,0);
    // R5 accepted write, upper bits dropped
    cyc(0,0,0,0,0,0,1,8'hFF,1,0);
    cyc(0,0,0,0,0,1,1,8'hFE,1,0);
    // R6 write without NAK, R7 write while busy
    cyc(0,0,0,0,0,0,1,8'h01,0,0);
    cyc(0,0,0,0,0,0,1,8'h01,1,1);
    // R8 clear beats write of 1; set beats write of 0
    cyc(0,1,0,0,0,0,1,8'h01,1,0);
    cyc(1,0,0,0,0,0,1,8'h00,1,0);
    // R10 query in the cycle the state changes returns the old value
    cyc(0,1,0,0,0,1,0,8'h00,0,0);
    idle();

    void'($urandom(32'h5EED));
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] r;
      r = 16'($urandom);
      cyc(r[0] & r[1] & r[2], r[3] & r[4] & r[5], r[6] & r[7] & r[8] & r[9],
          r[10] & r[11] & r[12] & r[13], r[14] & r[15] & r[0] & r[3],
          r[5] ^ r[9], r[1] | r[13], 8'($urandom), r[2] | r[7], r[4] & r[11]);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule